// File: doc/BRIEF.md
# Multichannel Serial ADC Frame Capture

This block pulls one conversion frame at a time out of an external eight-channel, 24-bit converter that shares a single serial data line. The block drives the serial clock itself. The length of each clock phase is set by a programmable count of system-clock cycles. A frame boundary is recognised only after the converter's data-ready line has been seen high and then low. The block then clocks in eight words back to back, most significant bit first, one word per channel. Each word goes out as a 32-bit result with a one-cycle valid strobe. The upper byte of that result carries the 1-based channel number.

Software or a higher-level sequencer holds `run_en` high to keep capturing frames. The enable is looked at only between frames. If it drops while a frame is in flight, that frame still completes, and the block then parks with the serial clock low. Storing the results is left to whatever consumes the valid/data stream.

The controller has six states:

- **IDLE**: nothing is running.
- **ARM**: waiting for data-ready to be high.
- **SYNC**: waiting for data-ready to fall.
- **CLK_HI**: serial clock high.
- **CLK_LO**: serial clock low; the data line is sampled in the first cycle of this phase.
- **EMIT**: presents one finished word.

The transitions are:

- IDLE→ARM when `run_en` is high.
- ARM→IDLE and SYNC→IDLE when `run_en` is low.
- ARM→SYNC when `drdy` is high.
- SYNC→CLK_HI when `drdy` is low. This is the frame start.
- CLK_HI→CLK_LO when the phase count expires.
- CLK_LO→CLK_HI when the phase expires and bits remain in the word.
- CLK_LO→EMIT when the phase expires and the word is complete.
- EMIT→CLK_HI when more channels remain.
- EMIT→IDLE after the last channel.

Top module: `adc_frame_capture`

## Requirements
- R1: While reset is applied and right after it is released, `sclk` and `word_valid` are low.
- R2: A frame starts only after `drdy` has been seen high and then low. With `run_en` high, `drdy` held low alone, or held high alone, produces no `sclk` pulse.
- R3: Each bit holds `sclk` high for exactly N system-clock cycles, where N is `half_period`, and a value of 0 is treated as 1. The low phase then lasts N cycles between bits of one channel and N+1 cycles across a channel boundary. N is sampled while no frame is running.
- R4: `sdata` is sampled in the first system-clock cycle after `sclk` falls. The first sampled bit of a channel ends up in word bit 23, so bits are taken most significant first.
- R5: Every frame produces exactly 24 `sclk` rising edges per channel, 192 per frame, and eight result words. The bit counter restarts at 24 for each channel.
- R6: `word_valid` is a single-cycle strobe. `word_data[23:0]` holds the sample and `word_data[31:24]` holds the channel number. The words of a frame arrive with channel numbers 0x01, 0x02, … 0x08 in that order.
- R7: Changes on `drdy` while a frame is being clocked in are ignored. The frame's words are unaffected.
- R8: `run_en` is examined only before a frame. If it is low when the frame finishes, the block returns to idle and ignores further `drdy` cycles, producing no `sclk` pulses and no words.
- R9: `sclk` is low between frames and in every cycle where `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Keep capturing frames while high |
| half_period | input | HP_W (16) | Serial clock phase length in system-clock cycles, 0 acts as 1 |
| drdy | input | 1 | Converter data-ready line |
| sdata | input | 1 | Converter serial data line |
| sclk | output | 1 | Serial clock to the converter |
| word_valid | output | 1 | One-cycle strobe marking a finished channel word |
| word_data | output | WORD_W (32) | Channel number in bits 31:24, sample in bits 23:0 |

## Verification
The pulse-width check compares against the live `half_period` input. It therefore assumes that input stays constant from the frame start until the last word. The stimulus changes it only while the block waits for data-ready. The channel-order and bit-count checks assume frames are never cut short, which holds because the block has no abort path other than reset. The converter model in the bench presents each new bit on the rising serial clock edge, which leaves a full high phase of setup before the sample point. It also toggles data-ready and drops the enable only inside a frame, where they must have no effect.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_SYNC   = 3'd2,
        ST_CLK_HI = 3'd3,
        ST_CLK_LO = 3'd4,
        ST_EMIT   = 3'd5
    } cap_state_e;

endpackage

// File: rtl/adc_cap_phase_timer.sv
// Down-counter that times one serial clock phase. fresh is high in the
// first cycle after a load, expire in the last cycle of the phase.
module adc_cap_phase_timer #(
    parameter int HP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [HP_W-1:0] load_val,
    output logic            fresh,
    output logic            expire
);

    logic [HP_W-1:0] cnt_q;
    logic            fresh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fresh_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            fresh_q <= 1'b1;
        end else begin
            fresh_q <= 1'b0;
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - HP_W'(1);
            end
        end
    end

    assign fresh  = fresh_q;
    assign expire = (cnt_q == HP_W'(1));

endmodule

// File: rtl/adc_cap_deser.sv
// Single shift register reused for every channel, with bit and channel counters.
module adc_cap_deser #(
    parameter int SAMPLE_W = 24,
    parameter int NUM_CH   = 8,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BIT_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift_en,
    input  logic                din,
    input  logic                advance,
    output logic [SAMPLE_W-1:0] sample,
    output logic [CH_W-1:0]     ch_idx,
    output logic                word_done,
    output logic                last_ch
);

    logic [SAMPLE_W-1:0] shreg_q;
    logic [BIT_W-1:0]    bits_left_q;
    logic [CH_W-1:0]     ch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            bits_left_q <= BIT_W'(SAMPLE_W);
            ch_q        <= '0;
        end else if (clear) begin
            shreg_q     <= '0;
            bits_left_q <= BIT_W'(SAMPLE_W);
            ch_q        <= '0;
        end else if (advance) begin
            shreg_q     <= '0;
            bits_left_q <= BIT_W'(SAMPLE_W);
            ch_q        <= ch_q + CH_W'(1);
        end else if (shift_en && (bits_left_q != '0)) begin
            shreg_q     <= {shreg_q[SAMPLE_W-2:0], din};
            bits_left_q <= bits_left_q - BIT_W'(1);
        end
    end

    // Complete once no bits are left, counting a shift happening this cycle.
    assign word_done = (bits_left_q == '0) ||
                       (shift_en && (bits_left_q == BIT_W'(1)));
    assign last_ch   = (ch_q == CH_W'(NUM_CH - 1));
    assign sample    = shreg_q;
    assign ch_idx    = ch_q;

endmodule

// File: rtl/adc_cap_fsm.sv
module adc_cap_fsm
    import adc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic drdy,
    input  logic tmr_fresh,
    input  logic tmr_expire,
    input  logic word_done,
    input  logic last_ch,
    output logic sclk,
    output logic word_valid,
    output logic frame_clear,
    output logic tmr_load,
    output logic shift_en,
    output logic advance,
    output logic frame_busy
);

    cap_state_e state_q;
    cap_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_en) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (!run_en)   state_d = ST_IDLE;
                else if (drdy) state_d = ST_SYNC;
            end
            ST_SYNC: begin
                if (!run_en)    state_d = ST_IDLE;
                else if (!drdy) state_d = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                if (tmr_expire) state_d = ST_CLK_LO;
            end
            ST_CLK_LO: begin
                if (tmr_expire) state_d = word_done ? ST_EMIT : ST_CLK_HI;
            end
            ST_EMIT: begin
                state_d = last_ch ? ST_IDLE : ST_CLK_HI;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sclk        = (state_q == ST_CLK_HI);
        word_valid  = (state_q == ST_EMIT);
        advance     = (state_q == ST_EMIT);
        shift_en    = (state_q == ST_CLK_LO) && tmr_fresh;
        frame_clear = (state_q == ST_SYNC) && (state_d == ST_CLK_HI);
        tmr_load    = ((state_q != ST_CLK_HI) && (state_d == ST_CLK_HI)) ||
                      ((state_q == ST_CLK_HI) && (state_d == ST_CLK_LO));
        frame_busy  = (state_q == ST_CLK_HI) || (state_q == ST_CLK_LO) ||
                      (state_q == ST_EMIT);
    end

endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture #(
    parameter int HP_W     = 16,
    parameter int SAMPLE_W = 24,
    parameter int NUM_CH   = 8,
    parameter int WORD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [HP_W-1:0]   half_period,
    input  logic              drdy,
    input  logic              sdata,
    output logic              sclk,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int TAG_W = WORD_W - SAMPLE_W;

    logic                tmr_fresh, tmr_expire, tmr_load;
    logic                word_done, last_ch;
    logic                frame_clear, shift_en, advance, frame_busy;
    logic [SAMPLE_W-1:0] sample;
    logic [CH_W-1:0]     ch_idx;
    logic [HP_W-1:0]     hp_q;
    logic [HP_W-1:0]     hp_eff;

    // Phase length is frozen for the whole frame.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hp_q <= HP_W'(1);
        end else if (!frame_busy) begin
            hp_q <= half_period;
        end
    end

    assign hp_eff = (hp_q == '0) ? HP_W'(1) : hp_q;

    adc_cap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .drdy        (drdy),
        .tmr_fresh   (tmr_fresh),
        .tmr_expire  (tmr_expire),
        .word_done   (word_done),
        .last_ch     (last_ch),
        .sclk        (sclk),
        .word_valid  (word_valid),
        .frame_clear (frame_clear),
        .tmr_load    (tmr_load),
        .shift_en    (shift_en),
        .advance     (advance),
        .frame_busy  (frame_busy)
    );

    adc_cap_phase_timer #(.HP_W(HP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (hp_eff),
        .fresh    (tmr_fresh),
        .expire   (tmr_expire)
    );

    adc_cap_deser #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_clear),
        .shift_en  (shift_en),
        .din       (sdata),
        .advance   (advance),
        .sample    (sample),
        .ch_idx    (ch_idx),
        .word_done (word_done),
        .last_ch   (last_ch)
    );

    assign word_data = {TAG_W'(ch_idx) + TAG_W'(1), sample};

endmodule

// File: rtl/adc_frame_capture_chk.sv
module adc_frame_capture_chk #(
    parameter int HP_W     = 16,
    parameter int SAMPLE_W = 24,
    parameter int WORD_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HP_W-1:0]   half_period,
    input logic              sclk,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data
);

    localparam int TAG_W = WORD_W - SAMPLE_W;

    logic              sclk_d;
    logic [HP_W:0]     hi_len;
    logic [15:0]       rise_cnt;
    logic [TAG_W-1:0]  prev_tag;
    logic [TAG_W-1:0]  tag;
    logic [HP_W:0]     hp_eff;

    assign tag    = word_data[WORD_W-1:SAMPLE_W];
    assign hp_eff = (half_period == '0) ? (HP_W+1)'(1) : {1'b0, half_period};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            hi_len   <= '0;
            rise_cnt <= '0;
            prev_tag <= '0;
        end else begin
            sclk_d <= sclk;
            hi_len <= sclk ? hi_len + (HP_W+1)'(1) : '0;
            if (word_valid)          rise_cnt <= '0;
            else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 16'd1;
            if (word_valid)          prev_tag <= tag;
        end
    end

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_tag_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (tag >= TAG_W'(1) && tag <= TAG_W'(8)));

    assert_tag_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && tag != TAG_W'(1)) |-> (tag == prev_tag + TAG_W'(1)));

    assert_sclk_low_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !sclk);

    assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk && sclk_d) |-> (hi_len == hp_eff));

    assert_rise_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (rise_cnt == 16'(SAMPLE_W)));

endmodule

bind adc_frame_capture adc_frame_capture_chk #(
    .HP_W     (HP_W),
    .SAMPLE_W (SAMPLE_W),
    .WORD_W   (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_period (half_period),
    .sclk        (sclk),
    .word_valid  (word_valid),
    .word_data   (word_data)
);

// File: tb/adc_frame_capture_tb_top.sv
`timescale 1ns/1ps
module adc_frame_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [15:0] half_period = 16'd2;
    logic        drdy = 1'b0;
    logic        sdata = 1'b0;
    logic        sclk;
    logic        word_valid;
    logic [31:0] word_data;

    int checks = 0;
    int fails = 0;
    int rises = 0;
    int width_err = 0;
    int hi_run = 0;
    int exp_hp = 1;
    logic sclk_prev = 1'b0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    adc_frame_capture dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .half_period (half_period),
        .drdy        (drdy),
        .sdata       (sdata),
        .sclk        (sclk),
        .word_valid  (word_valid),
        .word_data   (word_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pulse widths, rising edges, and scoreboard compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !sclk_prev) rises++;
            if (sclk) hi_run++;
            else if (hi_run != 0) begin
                if (hi_run != exp_hp) width_err++;
                hi_run = 0;
            end
            sclk_prev = sclk;
            if (word_valid) begin
                chk(sclk == 1'b0, "R9", "sclk high with word_valid", sclk, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected word", word_data, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(word_data == e, "R4 R6", "word", word_data, e);
                end
            end
        end
    end

    // Driver: converter model for one frame.
    task automatic do_frame(input logic [23:0] s [8], input int hp,
                            input bit glitch, input bit drop_run);
        half_period = 16'(hp);
        exp_hp = (hp == 0) ? 1 : hp;
        rises = 0;
        width_err = 0;
        for (int c = 0; c < 8; c++) exp_q.push_back({8'(c + 1), s[c]});
        repeat (3) @(negedge clk);
        drdy = 1'b1;
        repeat (4) @(negedge clk);
        drdy = 1'b0;
        for (int b = 0; b < 192; b++) begin
            @(posedge sclk);
            sdata = s[b / 24][23 - (b % 24)];
            if (glitch && b == 40) drdy = 1'b1;
            if (glitch && b == 90) drdy = 1'b0;
            if (drop_run && b == 60) run_en = 1'b0;
        end
        for (int t = 0; t < 4000 && exp_q.size() != 0; t++) @(negedge clk);
        repeat (2 * exp_hp + 6) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "words missing", exp_q.size(), 0);
        chk(rises == 192, "R5", "sclk rising edges", rises, 192);
        chk(width_err == 0, "R3", "high phase width errors", width_err, 0);
        chk(sclk == 1'b0, "R9", "sclk between frames", sclk, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(word_valid == 1'b0, "R1", "word_valid in reset", word_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0 && word_valid == 1'b0, "R1", "outputs after reset",
            {sclk, word_valid}, 0);

        // R2: drdy low alone, then high alone, starts nothing.
        run_en = 1'b1;
        rises = 0;
        repeat (60) @(negedge clk);
        chk(rises == 0, "R2", "sclk with drdy low only", rises, 0);
        drdy = 1'b1;
        repeat (30) @(negedge clk);
        chk(rises == 0, "R2", "sclk with drdy high only", rises, 0);

        do_frame('{24'h800001, 24'h123456, 24'hABCDEF, 24'h000000,
                   24'hFFFFFF, 24'h7FFFFE, 24'h555555, 24'hAAAAAA}, 1, 0, 0);
        do_frame('{24'hFFFFFF, 24'h000001, 24'h800000, 24'hC3C3C3,
                   24'h0F0F0F, 24'h246801, 24'hFEDCBA, 24'h13579B}, 3, 0, 0);
        do_frame('{24'h111111, 24'h222222, 24'h333333, 24'h444444,
                   24'h555555, 24'h666666, 24'h777777, 24'h888888}, 0, 0, 0);
        // R7: drdy toggles mid-frame.
        do_frame('{24'h9ABCDE, 24'h010203, 24'hF0F0F0, 24'h0000FF,
                   24'hFF0000, 24'h00FF00, 24'h5A5A5A, 24'hA5A5A5}, 2, 1, 0);
        // R8: run_en drops mid-frame; frame still finishes.
        do_frame('{24'h000100, 24'h001000, 24'h010000, 24'h100000,
                   24'h200000, 24'h400000, 24'h000002, 24'h000004}, 1, 0, 1);
        rises = 0;
        drdy = 1'b1;
        repeat (10) @(negedge clk);
        drdy = 1'b0;
        repeat (100) @(negedge clk);
        chk(rises == 0, "R8", "sclk after run_en low", rises, 0);
        chk(exp_q.size() == 0, "R8", "queue after idle", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule